// File: doc/BRIEF.md
# Flow Boundary Byte Prepender

This unit sits in a per-flow stream reassembly path, after segments have already been put in order. For every flow it remembers the final bytes of the most recent in-order payload. When that flow's next in-order payload passes through, the unit emits those remembered bytes first and then the new payload. A downstream byte-serial pattern matcher therefore sees a signature that straddles a segment boundary as one contiguous run.

Payload bytes arrive one per cycle with valid/ready, start and end markers, a flow number and an in-order flag. The flow number and the flag are taken from the start byte. Output is byte-serial with valid/ready. Each output byte carries a marker that says whether it was replayed from the store or taken from the current payload. A flow-clear strobe forgets a flow's stored bytes, for example when its connection closes. `EDGE_BYTES` sets how many bytes each flow keeps and may be 8, 16 or 32.

Top module: `edge_prepend_unit`

## Requirements
- R1: After reset no flow holds stored bytes, and while reset is asserted `out_valid_o` and `in_ready_o` are low. The first in-order packet of any flow is emitted byte for byte with nothing in front of it.
- R2: An in-order packet of a flow that holds stored bytes is emitted as the stored bytes, oldest first with `out_edge_o`=1, followed by its payload with `out_edge_o`=0. `out_sop_o` marks the first output byte and `out_eop_o` marks the last payload byte. A replayed byte never carries `out_eop_o`.
- R3: After an in-order packet of at least `EDGE_BYTES` bytes, the flow stores exactly that packet's last `EDGE_BYTES` payload bytes. Bytes that were replayed in front of the packet are never stored.
- R4: After an in-order packet shorter than `EDGE_BYTES`, the flow stores only that packet's bytes. The next in-order packet is preceded by exactly that many bytes.
- R5: A packet whose start byte has `in_inseq_i`=0 is emitted unchanged with nothing prepended, and it leaves the flow's stored bytes untouched.
- R6: Each flow's stored bytes are independent of the traffic on every other flow.
- R7: A `clr_valid_i` pulse for flow `clr_flow_i` removes that flow's stored bytes. The next in-order packet of that flow gets nothing prepended.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the output byte and its markers hold. No byte is lost or duplicated. `in_ready_o` is low while replayed bytes are being output.
- R9: During the payload phase each accepted input byte leaves on the same cycle, and `in_ready_o` follows `out_ready_i`. At most one byte moves per cycle.
- R10: No packet is preceded by more than `EDGE_BYTES` replayed bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when high with valid |
| in_data_i | input | 8 | Payload byte |
| in_sop_i | input | 1 | First byte of a packet |
| in_eop_i | input | 1 | Last byte of a packet |
| in_flow_i | input | FLOW_W | Flow number, taken with the start byte |
| in_inseq_i | input | 1 | Packet is in order, taken with the start byte |
| clr_valid_i | input | 1 | Forget the stored bytes of one flow |
| clr_flow_i | input | FLOW_W | Flow to forget |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Consumer takes the byte |
| out_data_o | output | 8 | Output byte |
| out_sop_o | output | 1 | First byte of an output packet |
| out_eop_o | output | 1 | Last byte of an output packet |
| out_edge_o | output | 1 | Byte was replayed from the store |

## Verification
The bench targets four failure classes:
- Counting and ordering. It sends packets shorter than, equal to and longer than the store, including a single-byte packet. A capture counter that wraps or fails to saturate would replay too many bytes or the wrong ones.
- Out-of-order packets. It sends such packets between in-order ones. A design that lets them write the store would replay their bytes on the next in-order packet.
- Flow separation and clearing. It interleaves flows and clears one of them. Crossed flow indexing or an ignored clear shows up as bytes replayed on the wrong packet.
- Backpressure. It applies random and alternating stalls across both phases. An index that advances without a handshake would skip or repeat a replayed byte.

// File: rtl/edge_pkg.sv
package edge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EDGE = 2'd1,
    ST_PAY  = 2'd2
  } ep_state_e;
endpackage

// File: rtl/edge_tail_capture.sv
module edge_tail_capture #(
  parameter int EDGE_BYTES = 32,
  parameter int CNT_W      = $clog2(EDGE_BYTES + 1)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic                             push_i,
  input  logic [7:0]                       byte_i,
  output logic [EDGE_BYTES-1:0][7:0]       tail_nxt_o,
  output logic [CNT_W-1:0]                 cnt_nxt_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(EDGE_BYTES);

  logic [EDGE_BYTES-1:0][7:0] tail_q;
  logic [CNT_W-1:0]           cnt_q;

  // newest byte sits at the top index
  for (genvar g = 0; g < EDGE_BYTES; g++) begin : g_shift
    if (g == EDGE_BYTES - 1) begin : g_top
      assign tail_nxt_o[g] = push_i ? byte_i : tail_q[g];
    end else begin : g_low
      assign tail_nxt_o[g] = push_i ? tail_q[g+1] : tail_q[g];
    end
  end

  assign cnt_nxt_o = (push_i && cnt_q != FULL) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt_o;
    end
  end

  always_ff @(posedge clk_i) begin
    tail_q <= tail_nxt_o;
  end
endmodule

// File: rtl/edge_flow_store.sv
module edge_flow_store #(
  parameter int FLOWS      = 16,
  parameter int EDGE_BYTES = 32,
  parameter int FLOW_W     = 4,
  parameter int CNT_W      = 6,
  parameter int IDX_W      = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [FLOW_W-1:0]          wr_flow_i,
  input  logic [EDGE_BYTES-1:0][7:0] wr_bytes_i,
  input  logic [CNT_W-1:0]           wr_cnt_i,
  input  logic                       clr_i,
  input  logic [FLOW_W-1:0]          clr_flow_i,
  input  logic [FLOW_W-1:0]          rd_flow_i,
  input  logic [IDX_W-1:0]           rd_idx_i,
  output logic                       rd_vld_o,
  output logic [CNT_W-1:0]           rd_cnt_o,
  output logic [7:0]                 rd_byte_o
);
  logic [FLOWS-1:0]           vld_q;
  logic [CNT_W-1:0]           cnt_q [FLOWS];
  logic [EDGE_BYTES-1:0][7:0] mem_q [FLOWS];

  for (genvar g = 0; g < FLOWS; g++) begin : g_flow
    logic wr_hit, clr_hit;
    assign wr_hit  = wr_i  && (wr_flow_i  == FLOW_W'(g));
    assign clr_hit = clr_i && (clr_flow_i == FLOW_W'(g));

    // clear wins over a same-cycle write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        cnt_q[g] <= '0;
      end else begin
        if (wr_hit) begin
          vld_q[g] <= 1'b1;
          cnt_q[g] <= wr_cnt_i;
        end
        if (clr_hit) vld_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk_i) begin
      if (wr_hit) mem_q[g] <= wr_bytes_i;
    end
  end

  assign rd_vld_o  = vld_q[rd_flow_i];
  assign rd_cnt_o  = cnt_q[rd_flow_i];
  assign rd_byte_o = mem_q[rd_flow_i][rd_idx_i];
endmodule

// File: rtl/edge_prepend_ctrl.sv
module edge_prepend_ctrl
  import edge_pkg::*;
#(
  parameter int EDGE_BYTES = 32,
  parameter int FLOW_W     = 4,
  parameter int CNT_W      = 6,
  parameter int IDX_W      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [FLOW_W-1:0] in_flow_i,
  input  logic              in_inseq_i,
  input  logic [7:0]        in_data_i,
  input  logic              out_ready_i,
  input  logic              st_vld_i,
  input  logic [CNT_W-1:0]  st_cnt_i,
  input  logic [7:0]        st_byte_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic              out_edge_o,
  output logic [FLOW_W-1:0] rd_flow_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              cap_start_o,
  output logic              cap_push_o,
  output logic              commit_o,
  output logic [FLOW_W-1:0] commit_flow_o
);
  localparam logic [CNT_W-1:0] EDGE_C   = CNT_W'(EDGE_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(EDGE_BYTES - 1);

  ep_state_e         state_q, state_d;
  logic [FLOW_W-1:0] flow_q;
  logic              inseq_q, first_q;
  logic [IDX_W-1:0]  idx_q;
  logic              start, has_edge, pay_hs;

  assign start    = (state_q == ST_IDLE) && in_valid_i && in_sop_i;
  assign has_edge = in_inseq_i && st_vld_i && (st_cnt_i != '0);
  assign pay_hs   = (state_q == ST_PAY) && in_valid_i && out_ready_i;

  assign rd_flow_o     = (state_q == ST_IDLE) ? in_flow_i : flow_q;
  assign rd_idx_o      = idx_q;
  assign cap_start_o   = start;
  assign cap_push_o    = pay_hs;
  assign commit_o      = pay_hs && in_eop_i && inseq_q;
  assign commit_flow_o = flow_q;

  always_comb begin
    state_d     = state_q;
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_data_o  = in_data_i;
    out_sop_o   = 1'b0;
    out_eop_o   = 1'b0;
    out_edge_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) state_d = has_edge ? ST_EDGE : ST_PAY;
      end
      ST_EDGE: begin
        out_valid_o = 1'b1;
        out_data_o  = st_byte_i;
        out_sop_o   = first_q;
        out_edge_o  = 1'b1;
        if (out_ready_i && idx_q == LAST_IDX) state_d = ST_PAY;
      end
      ST_PAY: begin
        in_ready_o  = out_ready_i;
        out_valid_o = in_valid_i;
        out_sop_o   = first_q;
        out_eop_o   = in_eop_i;
        if (pay_hs && in_eop_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      flow_q  <= '0;
      inseq_q <= 1'b0;
      first_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start) begin
        flow_q  <= in_flow_i;
        inseq_q <= in_inseq_i;
        first_q <= 1'b1;
        idx_q   <= IDX_W'(EDGE_C - st_cnt_i);
      end else if (out_valid_o && out_ready_i) begin
        first_q <= 1'b0;
        if (state_q == ST_EDGE) idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/edge_prepend_unit.sv
module edge_prepend_unit #(
  parameter int FLOWS      = 16,
  parameter int EDGE_BYTES = 32,
  parameter int FLOW_W     = (FLOWS > 1) ? $clog2(FLOWS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [FLOW_W-1:0] in_flow_i,
  input  logic              in_inseq_i,
  input  logic              clr_valid_i,
  input  logic [FLOW_W-1:0] clr_flow_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic              out_edge_o
);
  localparam int CNT_W = $clog2(EDGE_BYTES + 1);
  localparam int IDX_W = $clog2(EDGE_BYTES);

  if (!(EDGE_BYTES == 8 || EDGE_BYTES == 16 || EDGE_BYTES == 32)) begin : g_bad_edge
    $error("EDGE_BYTES must be 8, 16 or 32");
  end

  logic [EDGE_BYTES-1:0][7:0] tail_nxt;
  logic [CNT_W-1:0]           cnt_nxt, st_cnt;
  logic                       st_vld, cap_start, cap_push, commit;
  logic [7:0]                 st_byte;
  logic [FLOW_W-1:0]          rd_flow, commit_flow;
  logic [IDX_W-1:0]           rd_idx;

  edge_prepend_ctrl #(
    .EDGE_BYTES(EDGE_BYTES), .FLOW_W(FLOW_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .in_valid_i, .in_sop_i, .in_eop_i, .in_flow_i, .in_inseq_i,
    .in_data_i, .out_ready_i,
    .st_vld_i(st_vld), .st_cnt_i(st_cnt), .st_byte_i(st_byte),
    .in_ready_o, .out_valid_o, .out_data_o, .out_sop_o, .out_eop_o, .out_edge_o,
    .rd_flow_o(rd_flow), .rd_idx_o(rd_idx), .cap_start_o(cap_start),
    .cap_push_o(cap_push), .commit_o(commit), .commit_flow_o(commit_flow)
  );

  edge_tail_capture #(.EDGE_BYTES(EDGE_BYTES), .CNT_W(CNT_W)) u_cap (
    .clk_i, .rst_ni, .start_i(cap_start), .push_i(cap_push), .byte_i(in_data_i),
    .tail_nxt_o(tail_nxt), .cnt_nxt_o(cnt_nxt)
  );

  edge_flow_store #(
    .FLOWS(FLOWS), .EDGE_BYTES(EDGE_BYTES), .FLOW_W(FLOW_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i, .rst_ni, .wr_i(commit), .wr_flow_i(commit_flow), .wr_bytes_i(tail_nxt),
    .wr_cnt_i(cnt_nxt), .clr_i(clr_valid_i), .clr_flow_i, .rd_flow_i(rd_flow),
    .rd_idx_i(rd_idx), .rd_vld_o(st_vld), .rd_cnt_o(st_cnt), .rd_byte_o(st_byte)
  );
endmodule

// File: rtl/edge_prepend_unit_chk.sv
module edge_prepend_unit_chk #(
  parameter int EDGE_BYTES = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic [7:0] in_data_i,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input logic       out_eop_o,
  input logic       out_edge_o
);
  int run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 0;
    else if (out_valid_o && out_ready_i) run_q <= out_edge_o ? run_q + 1 : 0;
  end

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_edge_o)); // R8
  AST_EDGE_STALLS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_edge_o |-> !in_ready_o); // R8
  AST_EDGE_NOT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_edge_o |-> !out_eop_o); // R2
  AST_NO_EDGE_AFTER_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !out_edge_o && !out_eop_o |=> !out_edge_o); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |-> out_valid_o && out_ready_i && !out_edge_o && out_data_o == in_data_i); // R9
  AST_EDGE_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_edge_o |-> run_q < EDGE_BYTES); // R10
endmodule

bind edge_prepend_unit edge_prepend_unit_chk #(.EDGE_BYTES(EDGE_BYTES)) u_chk (.*);

// File: tb/edge_prepend_unit_test.sv
module edge_prepend_unit_test;
  localparam int FLOWS = 16;
  localparam int EDGE  = 32;
  localparam int FW    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, in_inseq = 0;
  logic [7:0] in_data = 0;
  logic [FW-1:0] in_flow = 0, clr_flow = 0;
  logic clr_valid = 0, out_ready = 1;
  logic in_ready, out_valid, out_sop, out_eop, out_edge;
  logic [7:0] out_data;

  edge_prepend_unit #(.FLOWS(FLOWS), .EDGE_BYTES(EDGE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_sop_i(in_sop), .in_eop_i(in_eop), .in_flow_i(in_flow),
    .in_inseq_i(in_inseq), .clr_valid_i(clr_valid), .clr_flow_i(clr_flow),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_sop_o(out_sop), .out_eop_o(out_eop), .out_edge_o(out_edge)
  );

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0, pkt_no = 0, rmode = 0, edge_run = 0;
  string cur_req = "R1";
  logic [10:0] exp_q[$];
  logic [7:0] m_edge [FLOWS][EDGE];
  int m_cnt [FLOWS];
  bit m_vld [FLOWS];
  bit stall_prev = 0;
  logic [8:0] held;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    case (rmode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom % 4) != 0;
      default: out_ready = ~out_ready;
    endcase
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!out_valid && !in_ready, "R1", "outputs quiet in reset", {out_valid, in_ready}, 0);
    end else begin
      if (stall_prev)
        chk(out_valid && {out_edge, out_data} == held, "R8", "stalled byte held",
            {out_valid, out_edge, out_data}, {1'b1, held});
      stall_prev = out_valid && !out_ready;
      held = {out_edge, out_data};
      if (out_valid && out_edge) chk(!in_ready, "R8", "input stalled in replay", in_ready, 0);
      if (out_valid && !out_edge) chk(in_ready == out_ready, "R9", "ready follows", in_ready, out_ready);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, cur_req, "unexpected output byte", {out_edge, out_sop, out_eop, out_data}, 0);
        end else begin
          chk({out_edge, out_sop, out_eop, out_data} == exp_q[0], cur_req, "edge/sop/eop/data",
              {out_edge, out_sop, out_eop, out_data}, exp_q[0]);
          void'(exp_q.pop_front());
        end
        edge_run = out_edge ? edge_run + 1 : 0;
        chk(edge_run <= EDGE, "R10", "replay length", edge_run, EDGE);
      end
    end
  end

  task automatic send_pkt(int f, bit inseq, int len, string req);
    logic [7:0] pl [$];
    int k;
    bit first;
    cur_req = req;
    pkt_no++;
    for (int i = 0; i < len; i++) pl.push_back(8'((pkt_no * 37 + i * 11 + f) & 8'hff));
    first = 1;
    if (inseq && m_vld[f] && m_cnt[f] > 0) begin
      for (int i = 0; i < m_cnt[f]; i++) begin
        exp_q.push_back({1'b1, first, 1'b0, m_edge[f][i]});
        first = 0;
      end
    end
    for (int i = 0; i < len; i++) begin
      exp_q.push_back({1'b0, first, (i == len - 1), pl[i]});
      first = 0;
    end
    for (int i = 0; i < len; i++) begin
      in_valid = 1; in_data = pl[i]; in_sop = (i == 0); in_eop = (i == len - 1);
      in_flow = FW'(f); in_inseq = inseq;
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1;
      in_valid = 0; in_sop = 0; in_eop = 0;
    end
    if (inseq) begin
      k = (len < EDGE) ? len : EDGE;
      for (int i = 0; i < k; i++) m_edge[f][i] = pl[len - k + i];
      m_cnt[f] = k;
      m_vld[f] = 1;
    end
  endtask

  task automatic clear_flow(int f);
    clr_valid = 1; clr_flow = FW'(f);
    @(posedge clk); #1;
    clr_valid = 0;
    m_vld[f] = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < FLOWS; i++) begin m_vld[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    rst_n = 1;
    send_pkt(0, 1, 40, "R1");
    send_pkt(0, 1, 20, "R2 R3");
    send_pkt(0, 1, 5, "R4");
    send_pkt(0, 1, 50, "R4");
    send_pkt(0, 1, 32, "R3");
    send_pkt(1, 0, 10, "R5");
    send_pkt(1, 1, 10, "R5 R1");
    send_pkt(0, 0, 7, "R5");
    send_pkt(0, 1, 9, "R5");
    send_pkt(2, 1, 12, "R6");
    send_pkt(3, 1, 45, "R6");
    send_pkt(2, 1, 3, "R6");
    send_pkt(3, 1, 1, "R6 R4");
    send_pkt(3, 1, 1, "R4");
    clear_flow(0);
    send_pkt(0, 1, 15, "R7");
    send_pkt(0, 1, 15, "R7");
    drain();
    rmode = 1;
    send_pkt(2, 1, 40, "R8");
    send_pkt(2, 1, 33, "R8");
    rmode = 2;
    send_pkt(2, 1, 8, "R8");
    send_pkt(2, 1, 2, "R8");
    rmode = 1;
    for (int n = 0; n < 40; n++) begin
      if ((n % 9) == 4) clear_flow(n % 4);
      send_pkt(n % 4, ($urandom % 5) != 0, 1 + ($urandom % 60), "R6 R8");
    end
    drain();
    chk(exp_q.size() == 0, "R2", "all expected bytes emitted", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule